// File: doc/BRIEF.md
# Watchdog Timer With Register Interface

This block is a watchdog timer that sits on a simple synchronous register bus. Software programs a control word, a reload value and a live count. The input clock first passes through an 8-bit programmable prescaler and then a divider that can be set to 16, 32, 64 or 128. Each divided tick decrements a 16-bit down-counter.

If software fails to refresh the counter before it runs out, the block raises a one-cycle interrupt pulse, a latched system reset request, or both, depending on two independent enable bits. It then reloads the counter from the reload register. Software keeps the system alive by periodically writing a fresh value into the count register.

Reads return the register contents in the same cycle as the address, with no wait state. Writes take effect at the clock edge on which the write enable is high.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0x8019: timer off, reset-on-expiry on, interrupt off, divider /128, prescaler 0x80. The reload and count registers read 0x8000, and both outputs are low.
- R2: The registers sit at byte address 0x0 (control), 0x4 (reload) and 0x8 (count). A read returns the current value, zero-extended to 32 bits, and any other address reads 0. In the control word, bit 0 is the reset enable, bit 2 the interrupt enable, bits 4:3 the divider select, bit 5 the run enable and bits 15:8 the prescaler value P. All other control bits read 0.
- R3: While running, one counter tick occurs every (P+1)*D input clocks. D is 16, 32, 64 or 128 for select codes 0, 1, 2 and 3.
- R4: Each tick decrements the count by one. A tick that finds the count at 0 is an expiry and loads the reload value. After the count is set to N and the timer is enabled, the first expiry's output appears (P+1)*D*(N+1) clocks after the enabling write edge.
- R5: A write to the count register loads the written value at once. In the same cycle it overrides any tick, which then causes neither a decrement nor an expiry. Refreshing the count often enough prevents any expiry.
- R6: While the run enable is 0 the count holds its value and the prescaler and divider restart. The first tick after enabling therefore comes a full (P+1)*D clocks after the enabling edge.
- R7: With the interrupt enable set, each expiry produces `irq` high for exactly one clock cycle.
- R8: With the reset enable set, an expiry drives `rst_req` high. It stays high, whatever is written afterwards, until the block reset is applied.
- R9: Writing the control word with the run enable and the reset enable both cleared stops the timer, and no reset request follows.
- R10: With the reset enable clear, expiries pulse only `irq` and never raise `rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the timer |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | Latched system reset request |
| irq | output | 1 | One-cycle expiry interrupt |

## Verification
The case hardest to reach from the ports is a timer that is stopped part-way through a prescaler and divider period and later restarted. Only the distance to the next tick reveals whether the partial period was really discarded. The stimulus enables the timer, lets it run for a count that is not a multiple of the tick period, and then disables it. It checks that the read-back count stays frozen, re-enables with count 0 and measures the cycles to the first interrupt. The sticky reset request is also exercised by writing a cleared control word after expiry, before the block reset is applied.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rst_req,
  output logic          irq
);
  localparam int DIV_W = 7;
  localparam logic [AW-1:0] OFS_CTRL = AW'(0);
  localparam logic [AW-1:0] OFS_RLD  = AW'(4);
  localparam logic [AW-1:0] OFS_CNT  = AW'(8);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);
  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(1) << (PRE_W - 1);
  localparam int CW = PRE_W + 8;

  logic             run_en, rst_en, irq_en;
  logic [1:0]       div_sel;
  logic [PRE_W-1:0] pre_val, pre_cnt;
  logic [DIV_W-1:0] div_cnt, div_mask;
  logic [CNT_W-1:0] reload, cnt;
  logic             wr_ctrl, wr_rld, wr_cnt, pre_tick, tick, expire;
  logic [CW-1:0]    ctrl_word;

  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_rld   = bus_we && (bus_addr == OFS_RLD);
  assign wr_cnt   = bus_we && (bus_addr == OFS_CNT);
  assign pre_tick = run_en && (pre_cnt == pre_val);
  assign div_mask = {div_sel == 2'd3, div_sel[1], div_sel != 2'd0, 4'hF};
  assign tick     = pre_tick && ((div_cnt & div_mask) == div_mask);
  assign expire   = tick && (cnt == '0) && !wr_cnt;
  assign ctrl_word = {pre_val, 2'b00, run_en, div_sel, irq_en, 1'b0, rst_en};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = DW'(ctrl_word);
      OFS_RLD:  bus_rdata = DW'(reload);
      OFS_CNT:  bus_rdata = DW'(cnt);
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      rst_en  <= 1'b1;
      irq_en  <= 1'b0;
      div_sel <= 2'd3;
      pre_val <= PRE_INIT;
      reload  <= CNT_INIT;
    end else begin
      if (wr_ctrl) begin
        rst_en  <= bus_wdata[0];
        irq_en  <= bus_wdata[2];
        div_sel <= bus_wdata[4:3];
        run_en  <= bus_wdata[5];
        pre_val <= bus_wdata[8 +: PRE_W];
      end
      if (wr_rld) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run_en) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= CNT_INIT;
    else if (wr_cnt)  cnt <= bus_wdata[CNT_W-1:0];
    else if (tick)    cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq <= expire && irq_en;
      if (expire && rst_en) rst_req <= 1'b1;
    end
  end

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R7
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ($past(cnt) == '0)); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (!run_en && !wr_cnt) |=> $stable(cnt)); // R6
  AST_NO_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!rst_en && !rst_req) |=> !rst_req); // R9
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  b_addr = 4'h0;
  logic        b_we = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_ctrl, m_rld, m_cnt, m_clk, m_pt;
  bit m_irq, m_rst;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .rst_req(rst_req), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h8019; m_rld = 32'h8000; m_cnt = 32'h8000;
      m_clk = 0; m_pt = 0; m_irq = 0; m_rst = 0;
    end else begin
      automatic int p = (m_ctrl >> 8) & 255;
      automatic int d = 16 << ((m_ctrl >> 3) & 3);
      automatic bit ptick = 0, tk = 0, ex;
      automatic bit wcnt = b_we && b_addr == 4'h8;
      if (m_ctrl & 32'h20) begin
        if ((m_clk + 1) % (p + 1) == 0) ptick = 1;
        m_clk++;
        if (ptick) begin
          if ((m_pt + 1) % d == 0) tk = 1;
          m_pt++;
        end
      end else begin
        m_clk = 0; m_pt = 0;
      end
      ex = tk && m_cnt == 0 && !wcnt;
      m_irq = ex && (m_ctrl & 4) != 0;
      if (ex && (m_ctrl & 1)) m_rst = 1;
      if (wcnt) m_cnt = b_wdata & 32'hFFFF;
      else if (tk) m_cnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
      if (b_we && b_addr == 4'h0) m_ctrl = b_wdata & 32'hFF3D;
      if (b_we && b_addr == 4'h4) m_rld = b_wdata & 32'hFFFF;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int exp_rd = (b_addr == 0) ? m_ctrl : (b_addr == 4) ? m_rld :
                             (b_addr == 8) ? m_cnt : 0;
      chk("R7 irq model", irq, m_irq);
      chk("R8 rst_req model", rst_req, m_rst);
      chk("R2 rdata model", rdata, exp_rd);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    b_addr = a; b_we = 1'b1; b_wdata = d;
    step();
    b_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    b_addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin step(); if (irq) pulses++; end
  endtask

  task automatic time_first(input int ctrl, input int n, output int k);
    wr(4'h0, 0);
    wr(4'h8, n);
    wr(4'h0, ctrl);
    k = 0;
    while (!irq && k < 20000) begin step(); k++; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    automatic int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000 && !done) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    int v, v2, k, n;
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    step();
    rd(4'h0, v); chk("R1 ctrl reset", v, 32'h8019);
    rd(4'h4, v); chk("R1 reload reset", v, 32'h8000);
    rd(4'h8, v); chk("R1 count reset", v, 32'h8000);
    chk("R1 outputs reset", {rst_req, irq}, 0);

    wr(4'h0, 32'h12DE); rd(4'h0, v); chk("R2 ctrl readback", v, 32'h121C);
    wr(4'h4, 32'hABCD); rd(4'h4, v); chk("R2 reload readback", v, 32'hABCD);
    wr(4'h8, 32'h1234); rd(4'h8, v); chk("R2 count readback", v, 32'h1234);
    rd(4'hC, v); chk("R2 unmapped reads 0", v, 0);

    wr(4'h4, 0);
    time_first(32'h0024, 0, k); chk("R3 first expiry P0 /16 N0", k, 16);
    time_first(32'h022C, 3, k); chk("R4 first expiry P2 /32 N3", k, 384);
    time_first(32'h013C, 1, k); chk("R3 first expiry P1 /128 N1", k, 512);
    time_first(32'h0034, 0, k); chk("R3 first expiry P0 /64 N0", k, 64);

    wr(4'h0, 0); wr(4'h4, 2); wr(4'h8, 2); wr(4'h0, 32'h0024);
    idle(480, n); chk("R7 pulse count over 480 clocks", n, 10);
    chk("R10 no reset in irq mode", rst_req, 0);

    wr(4'h0, 0); wr(4'h8, 2); wr(4'h0, 32'h0024);
    n = 0;
    for (int j = 0; j < 20; j++) begin
      wr(4'h8, 2); if (irq) n++;
      idle(19, k); n += k;
    end
    chk("R5 keepalive prevents expiry", n, 0);
    rd(4'h8, v); chk("R5 count reloaded by write", v >= 0 && v <= 2, 1);

    wr(4'h0, 0); wr(4'h8, 100); wr(4'h0, 32'h0024);
    idle(203, n);
    wr(4'h0, 32'h0004);
    rd(4'h8, v); idle(300, n); rd(4'h8, v2);
    chk("R6 count frozen while off", v2, v);
    chk("R6 no pulse while off", n, 0);
    time_first(32'h0024, 0, k); chk("R6 full period after restart", k, 16);

    wr(4'h0, 0); wr(4'h4, 1);
    time_first(32'h0025, 1, k); chk("R4 expiry with both enables", k, 32);
    chk("R8 reset request raised", rst_req, 1);
    idle(100, n); chk("R8 reset request held", rst_req, 1);
    wr(4'h0, 0); idle(50, n); chk("R8 held after control cleared", rst_req, 1);

    @(posedge clk); #2; rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R8 cleared by block reset", rst_req, 0);
    rd(4'h0, v); chk("R1 ctrl after second reset", v, 32'h8019);

    wr(4'h4, 3); wr(4'h8, 3); wr(4'h0, 32'h0021);
    idle(30, n);
    wr(4'h0, 0);
    idle(500, n);
    chk("R9 stop prevents reset request", rst_req, 0);
    chk("R9 no pulse after stop", n, 0);

    step();
    finish_run();
  end
endmodule